// File: doc/BRIEF.md
# ADC Conversion Sequence Flow Controller

This block steps an analog-to-digital converter through a list of conversion commands. It holds a pointer into one of two command lists, issues one conversion per command, waits for the converter to finish, and then decides from the command's type field whether to continue, pause, or finish the list. The converter is represented inside the block as a fixed-latency busy/done counter. The stored-result event is a single-cycle `result_store` pulse.

Three events drive the flow: trigger, restart and sequence abort. Each event can come from the rising edge of a hardware level input or from a one-cycle software write pulse. The two are equivalent. In double-buffer mode, a load-ready flag decides whether a restart rewinds the active list or switches to the other list. The flag's timing relative to the restart request is what counts.

In restart mode, the controller enforces an abort-then-restart interlock. A trigger arriving before the restart locks the controller until a soft reset. A restart issued while a list is still open forces an automatic abort. Both violations raise error flags that only a soft reset or the hardware reset clears.

Top module: `adc_seqflow_ctrl`

## Requirements
- R1: After `rst_n` low or a `soft_rst` pulse, the block is in the following state: `seq_idle`=1, `cmd_ptr`=0, `list_sel`=0 and `list_done`=1. All of `trig_bit`, `rstrt_bit`, `abort_bit`, `load_ok`, `trig_err`, `rstrt_err` and `conv_busy` are 0.
- R2: A trigger request sets `trig_bit` at the next edge. If the controller is idle and allowed to run, `trig_bit` clears one edge later, when the list starts. Then `conv_start` is high for one cycle, `conv_busy` is high for CONV_LAT cycles, and `result_store` pulses in the last busy cycle.
- R3: The command type input encodes what happens after each conversion. 2'b00 moves to the next entry and converts again. 2'b01 (end of sequence) moves to the next entry and goes idle. 2'b10 (end of list) returns the pointer to 0, sets `list_done` and goes idle. The pointer wraps from LIST_DEPTH-1 to 0.
- R4: A restart requested before `load_ok` is set rewinds the active list to entry 0 and does not switch lists.
- R5: A restart requested while `load_ok` is set, or in the same cycle as `load_ok_set`, switches `list_sel` and clears `load_ok`, but only when `dbuf_en`=1. With `dbuf_en`=0 there is no switch and `load_ok` stays set.
- R6: An abort request is accepted only while `list_done`=0. Otherwise `abort_bit` stays 0.
- R7: An abort accepted during a conversion lets that conversion finish and store its result. No further conversion starts. At that boundary, `abort_bit` clears, `list_done` sets, the pointer returns to 0 and the controller goes idle.
- R8: In restart mode (`restart_mode`=1), a trigger after an executed abort and before a completed restart has these effects: `trig_err`=1 and `trig_bit` stays 1. No conversion starts and restart requests are ignored until a soft reset.
- R9: In restart mode, a restart after an executed abort starts no conversion. A later trigger converts from entry 0 of the active list.
- R10: A restart requested while `list_done`=0 and no abort is pending sets `abort_bit` and `rstrt_err` at the next edge. The abort runs first and the restart follows.
- R11: A restart request sets `rstrt_bit` at the next edge. When the controller is idle with the list done, the restart takes effect one edge later and `rstrt_bit` clears on the edge after that.
- R12: `trig_err` and `rstrt_err` stay set until `soft_rst` or `rst_n`.
- R13: A rising edge on `trig_in`, `rstrt_in` or `abort_in` has the same effect as a pulse on `sw_trig`, `sw_rstrt` or `sw_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| restart_mode | input | 1 | 1 = restart mode, 0 = trigger mode |
| dbuf_en | input | 1 | Enables switching between the two lists |
| trig_in | input | 1 | Hardware trigger level (rising edge used) |
| rstrt_in | input | 1 | Hardware restart level (rising edge used) |
| abort_in | input | 1 | Hardware abort level (rising edge used) |
| sw_trig | input | 1 | Software trigger write pulse |
| sw_rstrt | input | 1 | Software restart write pulse |
| sw_abort | input | 1 | Software abort write pulse |
| load_ok_set | input | 1 | Marks the inactive list as ready |
| cmd_type | input | 2 | Type of the command at `list_sel`/`cmd_ptr` |
| list_sel | output | 1 | Active list |
| cmd_ptr | output | PTR_W | Current command entry |
| conv_start | output | 1 | Conversion start pulse |
| conv_busy | output | 1 | Conversion in progress |
| result_store | output | 1 | Result stored pulse |
| trig_bit | output | 1 | Trigger pending |
| rstrt_bit | output | 1 | Restart pending |
| abort_bit | output | 1 | Abort pending |
| load_ok | output | 1 | Load-ready flag |
| list_done | output | 1 | End of list or abort executed |
| seq_idle | output | 1 | Controller idle |
| trig_err | output | 1 | Trigger-before-restart error |
| rstrt_err | output | 1 | Unexpected restart error |

## Verification
The hazardous internal states are a stale pending bit, a wrong list-done flag or a latched wrong swap decision. A stale pending bit shows on the event-bit outputs within one or two edges of the request, so the bench samples those bits cycle by cycle after each request. A wrong list-done flag or a wrong swap decision stays hidden until the next trigger. It then appears as a wrong pointer, a wrong `list_sel` or a wrong count of `result_store` pulses. For that reason each event in the vector walk is followed by a full settle and a check of pointer, list, done flag and stored-result count.

// File: rtl/adc_seq_pkg.sv
// Package: shared types and constants of the ADC sequence flow controller.
// Assumes: a command type field of two bits supplied with each list entry.
package adc_seq_pkg;

    // Command type carried by each list entry
    typedef enum logic [1:0] {
        CMD_CONV = 2'b00,
        CMD_EOS  = 2'b01,
        CMD_EOL  = 2'b10,
        CMD_RSVD = 2'b11
    } cmd_kind_e;

    // Flow controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_LOCK  = 2'd3
    } flow_state_e;

    // Event vector bit positions
    localparam int unsigned EVT_TRIG  = 0;
    localparam int unsigned EVT_RSTRT = 1;
    localparam int unsigned EVT_ABORT = 2;
    localparam int unsigned EVT_NUM   = 3;

endpackage

// File: rtl/adc_evt_edge.sv
// Module: merges hardware level inputs (rising edge) with software write
// pulses into one request pulse per event.
// Assumes: level inputs are synchronous to clk; software pulses last one cycle.
module adc_evt_edge #(
    parameter int unsigned N = 3
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] sw_set,
    output logic [N-1:0] req
);

    logic [N-1:0] lvl_q;

    for (genvar g = 0; g < N; g++) begin : g_evt
        // Remember the previous level of this event input
        always_ff @(posedge clk) begin
            if (!rst_n) lvl_q[g] <= 1'b0;
            else        lvl_q[g] <= lvl[g];
        end
        // Request on rising edge or on software write
        assign req[g] = (lvl[g] & ~lvl_q[g]) | sw_set[g];
    end

endmodule

// File: rtl/adc_conv_model.sv
// Module: fixed-latency stand-in for the analog conversion.
// Assumes: start only arrives while not busy; LAT >= 1.
module adc_conv_model #(
    parameter int unsigned LAT = 4
)(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int unsigned CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt;

    // Load the latency on start and count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n || clr)      cnt <= '0;
        else if (start)         cnt <= CW'(LAT);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

endmodule

// File: rtl/adc_list_bank.sv
// Module: command pointer, active-list select and load-ready flag.
// Assumes: ptr_top and ptr_step are never both requested in one cycle.
module adc_list_bank #(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned PW    = 3
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ptr_top,
    input  logic          ptr_step,
    input  logic          swap,
    input  logic          lok_set,
    output logic [PW-1:0] ptr,
    output logic          sel,
    output logic          lok
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    // Pointer movement with wrap at the last entry
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  ptr <= '0;
        else if (ptr_top)   ptr <= '0;
        else if (ptr_step)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // Active list toggles on an approved swap
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sel <= 1'b0;
        else if (swap)     sel <= ~sel;
    end

    // Load-ready flag: set by software, consumed by a swap
    always_ff @(posedge clk) begin
        if (!rst_n || clr) lok <= 1'b0;
        else if (lok_set)  lok <= 1'b1;
        else if (swap)     lok <= 1'b0;
    end

endmodule

// File: rtl/adc_seqflow_ctrl.sv
// Module: ADC conversion sequence flow controller (top).
// Walks a command list, runs one conversion per entry and handles trigger,
// restart and abort events with their interlocks and error flags.
// Assumes: cmd_type reflects the entry at list_sel/cmd_ptr in the same cycle.
module adc_seqflow_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned LIST_DEPTH = 6,
    parameter int unsigned CONV_LAT   = 4,
    localparam int unsigned PTR_W = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             restart_mode,
    input  logic             dbuf_en,
    input  logic             trig_in,
    input  logic             rstrt_in,
    input  logic             abort_in,
    input  logic             sw_trig,
    input  logic             sw_rstrt,
    input  logic             sw_abort,
    input  logic             load_ok_set,
    input  logic [1:0]       cmd_type,
    output logic             list_sel,
    output logic [PTR_W-1:0] cmd_ptr,
    output logic             conv_start,
    output logic             conv_busy,
    output logic             result_store,
    output logic             trig_bit,
    output logic             rstrt_bit,
    output logic             abort_bit,
    output logic             load_ok,
    output logic             list_done,
    output logic             seq_idle,
    output logic             trig_err,
    output logic             rstrt_err
);

    logic [EVT_NUM-1:0] evt_lvl, evt_sw, evt_req;
    flow_state_e state, nxt;
    cmd_kind_e   kind_q;
    logic trig_q, rstrt_q, abort_q, rs_done_q, rs_swap_q;
    logic done_q, need_rs_q, trig_err_q, rstrt_err_q;
    logic trig_take, rs_take, ab_take, auto_abort, trig_fault, locked;
    logic do_abort, do_restart, do_start, mark_eol, ptr_top, ptr_step, conv_go;
    logic conv_done;

    assign evt_lvl[EVT_TRIG]  = trig_in;
    assign evt_lvl[EVT_RSTRT] = rstrt_in;
    assign evt_lvl[EVT_ABORT] = abort_in;
    assign evt_sw[EVT_TRIG]   = sw_trig;
    assign evt_sw[EVT_RSTRT]  = sw_rstrt;
    assign evt_sw[EVT_ABORT]  = sw_abort;

    adc_evt_edge #(.N(EVT_NUM)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (evt_lvl),
        .sw_set (evt_sw),
        .req    (evt_req)
    );

    adc_conv_model #(.LAT(CONV_LAT)) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .start (conv_go),
        .busy  (conv_busy),
        .done  (conv_done)
    );

    adc_list_bank #(.DEPTH(LIST_DEPTH), .PW(PTR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .ptr_top  (ptr_top),
        .ptr_step (ptr_step),
        .swap     (do_restart & rs_swap_q),
        .lok_set  (load_ok_set),
        .ptr      (cmd_ptr),
        .sel      (list_sel),
        .lok      (load_ok)
    );

    // Event acceptance and interlock decisions
    always_comb begin
        locked     = (state == ST_LOCK);
        trig_take  = evt_req[EVT_TRIG] && !locked;
        ab_take    = evt_req[EVT_ABORT] && !done_q;
        rs_take    = evt_req[EVT_RSTRT] && !locked && !rstrt_q;
        auto_abort = rs_take && !done_q && !abort_q && !ab_take;
        trig_fault = trig_take && restart_mode && need_rs_q;
    end

    // Next-state and action decode of the flow machine
    always_comb begin
        nxt        = state;
        do_abort   = 1'b0;
        do_restart = 1'b0;
        do_start   = 1'b0;
        mark_eol   = 1'b0;
        ptr_step   = 1'b0;
        conv_go    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (trig_fault)
                    nxt = ST_LOCK;
                else if (abort_q)
                    do_abort = 1'b1;
                else if (rstrt_q && !rs_done_q && done_q)
                    do_restart = 1'b1;
                else if (trig_q && !need_rs_q && !rstrt_q) begin
                    do_start = 1'b1;
                    nxt      = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                conv_go = 1'b1;
                nxt     = ST_WAIT;
            end
            ST_WAIT: begin
                if (conv_done) begin
                    if (abort_q) begin
                        do_abort = 1'b1;
                        nxt      = ST_IDLE;
                    end else begin
                        case (kind_q)
                            CMD_EOS: begin
                                ptr_step = 1'b1;
                                nxt      = ST_IDLE;
                            end
                            CMD_EOL: begin
                                mark_eol = 1'b1;
                                nxt      = ST_IDLE;
                            end
                            default: begin
                                ptr_step = 1'b1;
                                nxt      = ST_ISSUE;
                            end
                        endcase
                    end
                end
            end
            ST_LOCK: nxt = ST_LOCK;
            default: nxt = ST_IDLE;
        endcase
        ptr_top = do_abort | do_restart | mark_eol;
    end

    // State register and event/flag bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state       <= ST_IDLE;
            kind_q      <= CMD_CONV;
            trig_q      <= 1'b0;
            rstrt_q     <= 1'b0;
            abort_q     <= 1'b0;
            rs_done_q   <= 1'b0;
            rs_swap_q   <= 1'b0;
            done_q      <= 1'b1;
            need_rs_q   <= 1'b0;
            trig_err_q  <= 1'b0;
            rstrt_err_q <= 1'b0;
        end else begin
            state <= nxt;
            if (do_start)  trig_q <= 1'b0;
            if (trig_take) trig_q <= 1'b1;
            if (trig_fault) trig_err_q <= 1'b1;
            if (rs_done_q) begin
                rstrt_q   <= 1'b0;
                rs_done_q <= 1'b0;
            end
            if (rs_take) begin
                rstrt_q   <= 1'b1;
                rs_swap_q <= dbuf_en & (load_ok | load_ok_set);
            end
            if (do_restart) begin
                rs_done_q <= 1'b1;
                need_rs_q <= 1'b0;
                done_q    <= 1'b0;
            end
            if (ab_take || auto_abort) abort_q <= 1'b1;
            if (auto_abort) rstrt_err_q <= 1'b1;
            if (do_abort) begin
                abort_q   <= 1'b0;
                done_q    <= 1'b1;
                need_rs_q <= restart_mode;
            end
            if (mark_eol) done_q <= 1'b1;
            if (do_start) done_q <= 1'b0;
            if (conv_go)  kind_q <= cmd_kind_e'(cmd_type);
        end
    end

    assign conv_start   = conv_go;
    assign result_store = conv_done;
    assign trig_bit     = trig_q;
    assign rstrt_bit    = rstrt_q;
    assign abort_bit    = abort_q;
    assign list_done    = done_q;
    assign seq_idle     = (state == ST_IDLE);
    assign trig_err     = trig_err_q;
    assign rstrt_err    = rstrt_err_q;

endmodule

// File: rtl/adc_seqflow_chk.sv
// Module: protocol checker for the flow controller, bound to the top.
// Assumes: observes ports only; all properties are reset-gated.
module adc_seqflow_chk #(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned PW    = 3
)(
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          conv_start,
    input logic          conv_busy,
    input logic          result_store,
    input logic          abort_bit,
    input logic          list_done,
    input logic          seq_idle,
    input logic          trig_err,
    input logic          rstrt_err,
    input logic [PW-1:0] cmd_ptr
);

    localparam logic [PW:0] PTR_LIM = (PW+1)'(DEPTH);

    assert_start_when_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !conv_busy);

    assert_store_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        result_store |-> conv_busy);

    assert_busy_not_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |-> !seq_idle);

    assert_ptr_in_list_R3: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cmd_ptr} < PTR_LIM);

    assert_abort_open_list_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort_bit ##1 abort_bit) |-> !$past(list_done));

    assert_abort_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_bit && result_store) |=> (!abort_bit && seq_idle && list_done));

    assert_no_conv_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_err |-> !conv_start);

    assert_auto_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rstrt_err ##1 rstrt_err) |-> abort_bit);

    assert_trig_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_err && !soft_rst) |=> trig_err);

    assert_rstrt_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rstrt_err && !soft_rst) |=> rstrt_err);

endmodule

bind adc_seqflow_ctrl adc_seqflow_chk #(.DEPTH(LIST_DEPTH), .PW(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .conv_start   (conv_start),
    .conv_busy    (conv_busy),
    .result_store (result_store),
    .abort_bit    (abort_bit),
    .list_done    (list_done),
    .seq_idle     (seq_idle),
    .trig_err     (trig_err),
    .rstrt_err    (rstrt_err),
    .cmd_ptr      (cmd_ptr)
);

// File: tb/adc_seqflow_ctrl_tb_top.sv
module adc_seqflow_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, restart_mode = 1'b0, dbuf_en = 1'b1;
    logic trig_in = 1'b0, rstrt_in = 1'b0, abort_in = 1'b0;
    logic sw_trig = 1'b0, sw_rstrt = 1'b0, sw_abort = 1'b0, load_ok_set = 1'b0;
    logic [1:0] cmd_type;
    logic list_sel, conv_start, conv_busy, result_store;
    logic trig_bit, rstrt_bit, abort_bit, load_ok, list_done, seq_idle;
    logic trig_err, rstrt_err;
    logic [2:0] cmd_ptr;

    int checks = 0;
    int errors = 0;
    int n_store = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    // Command lists: list0 = C C EOS C EOL C, list1 = C EOS EOL ...
    function automatic logic [1:0] cmd_of(input logic l, input logic [2:0] p);
        if (!l) return (p == 3'd2) ? 2'b01 : (p == 3'd4) ? 2'b10 : 2'b00;
        return (p == 3'd1) ? 2'b01 : (p == 3'd2) ? 2'b10 : 2'b00;
    endfunction
    assign cmd_type = cmd_of(list_sel, cmd_ptr);

    adc_seqflow_ctrl #(.LIST_DEPTH(6), .CONV_LAT(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .restart_mode(restart_mode),
        .dbuf_en(dbuf_en), .trig_in(trig_in), .rstrt_in(rstrt_in), .abort_in(abort_in),
        .sw_trig(sw_trig), .sw_rstrt(sw_rstrt), .sw_abort(sw_abort),
        .load_ok_set(load_ok_set), .cmd_type(cmd_type), .list_sel(list_sel),
        .cmd_ptr(cmd_ptr), .conv_start(conv_start), .conv_busy(conv_busy),
        .result_store(result_store), .trig_bit(trig_bit), .rstrt_bit(rstrt_bit),
        .abort_bit(abort_bit), .load_ok(load_ok), .list_done(list_done),
        .seq_idle(seq_idle), .trig_err(trig_err), .rstrt_err(rstrt_err)
    );

    always @(posedge clk) if (rst_n && result_store) n_store <= n_store + 1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: got %0d cycles expected below 20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    localparam logic [2:0] A_TSW = 3'd0, A_THW = 3'd1, A_RSW = 3'd2, A_RHW = 3'd3,
                           A_ASW = 3'd4, A_AHW = 3'd5, A_LOK = 3'd6;

    task automatic act(input logic [2:0] a);
        case (a)
            A_TSW: begin sw_trig = 1'b1;     tick(1); sw_trig = 1'b0;     end
            A_THW: begin trig_in = 1'b1;     tick(1); trig_in = 1'b0;     end
            A_RSW: begin sw_rstrt = 1'b1;    tick(1); sw_rstrt = 1'b0;    end
            A_RHW: begin rstrt_in = 1'b1;    tick(1); rstrt_in = 1'b0;    end
            A_ASW: begin sw_abort = 1'b1;    tick(1); sw_abort = 1'b0;    end
            A_AHW: begin abort_in = 1'b1;    tick(1); abort_in = 1'b0;    end
            default: begin load_ok_set = 1'b1; tick(1); load_ok_set = 1'b0; end
        endcase
    endtask

    task automatic sreset();
        soft_rst = 1'b1; tick(1); soft_rst = 1'b0; tick(1);
    endtask

    typedef struct packed {
        logic [2:0] a;
        logic [2:0] ptr;
        logic       lst;
        logic       dn;
        logic [2:0] st;
        logic       rerr;
        logic       lok;
    } step_t;

    // Trigger-mode walk, double buffering on
    localparam step_t STEPS [9] = '{
        '{A_TSW, 3'd3, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0},  // R2 R3 EOS stop
        '{A_THW, 3'd0, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0},  // R3 R13 EOL wrap
        '{A_LOK, 3'd0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1},
        '{A_RSW, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0},  // R5 swap
        '{A_THW, 3'd2, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0},
        '{A_RHW, 3'd0, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0},  // R10 R13 auto abort
        '{A_ASW, 3'd0, 1'b1, 1'b1, 3'd0, 1'b1, 1'b0},  // R6 accepted
        '{A_AHW, 3'd0, 1'b1, 1'b1, 3'd0, 1'b1, 1'b0},  // R6 ignored
        '{A_TSW, 3'd2, 1'b1, 1'b0, 3'd2, 1'b1, 1'b0}   // R12 sticky
    };

    initial begin
        int base;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 idle", seq_idle, 1);
        chk("R1 ptr", cmd_ptr, 0);
        chk("R1 list", list_sel, 0);
        chk("R1 done", list_done, 1);
        chk("R1 bits", {trig_bit, rstrt_bit, abort_bit, load_ok}, 0);
        chk("R1 errs", {trig_err, rstrt_err, conv_busy}, 0);

        for (int i = 0; i < 9; i++) begin
            base = n_store;
            act(STEPS[i].a);
            tick(40);
            chk($sformatf("R3 step%0d ptr", i), cmd_ptr, STEPS[i].ptr);
            chk($sformatf("R5 step%0d list", i), list_sel, STEPS[i].lst);
            chk($sformatf("R6 step%0d done", i), list_done, STEPS[i].dn);
            chk($sformatf("R2 step%0d stores", i), n_store - base, STEPS[i].st);
            chk($sformatf("R10 step%0d rstrt_err", i), rstrt_err, STEPS[i].rerr);
            chk($sformatf("R5 step%0d load_ok", i), load_ok, STEPS[i].lok);
            chk($sformatf("R6 step%0d pending", i), {trig_bit, rstrt_bit, abort_bit, trig_err}, 0);
        end

        // R1 soft reset clears sticky error and list select
        sreset();
        chk("R1 soft clears err", rstrt_err, 0);
        chk("R1 soft list", list_sel, 0);
        chk("R1 soft done", list_done, 1);

        // R2 cycle timing of trigger and conversion
        sw_trig = 1'b1; tick(1); sw_trig = 1'b0;
        chk("R2 trig set", trig_bit, 1);
        tick(1);
        chk("R2 trig cleared", trig_bit, 0);
        chk("R2 conv_start", conv_start, 1);
        tick(1);
        chk("R2 busy", conv_busy, 1);
        chk("R2 no early store", result_store, 0);
        tick(3);
        chk("R2 store last busy", result_store, 1);
        tick(40);
        sreset();

        // R11 restart bit lifetime
        sw_rstrt = 1'b1; tick(1); sw_rstrt = 1'b0;
        chk("R11 set", rstrt_bit, 1);
        tick(1);
        chk("R11 held", rstrt_bit, 1);
        tick(1);
        chk("R11 cleared", rstrt_bit, 0);
        // R4 load-ok after restart: no swap
        act(A_LOK); tick(5);
        chk("R4 list kept", list_sel, 0);
        chk("R4 load_ok", load_ok, 1);
        sreset();
        // R5 same-cycle load-ok and restart: swap
        sw_rstrt = 1'b1; load_ok_set = 1'b1; tick(1);
        sw_rstrt = 1'b0; load_ok_set = 1'b0; tick(5);
        chk("R5 same cycle swap", list_sel, 1);
        chk("R5 lok consumed", load_ok, 0);
        sreset();
        // R5 no swap without double buffering
        dbuf_en = 1'b0;
        act(A_LOK); act(A_RSW); tick(5);
        chk("R5 dbuf off list", list_sel, 0);
        chk("R5 dbuf off lok", load_ok, 1);
        dbuf_en = 1'b1;
        sreset();

        // R10 auto abort visible one edge after restart request
        act(A_TSW); tick(30);
        sw_rstrt = 1'b1; tick(1); sw_rstrt = 1'b0;
        chk("R10 abort set", abort_bit, 1);
        chk("R10 err set", rstrt_err, 1);
        tick(10);
        sreset();

        // R7 abort during a conversion
        sw_trig = 1'b1; tick(1); sw_trig = 1'b0;
        while (!conv_busy) tick(1);
        base = n_store;
        act(A_ASW);
        while (!result_store) tick(1);
        chk("R7 abort held to boundary", abort_bit, 1);
        tick(1);
        chk("R7 abort cleared", abort_bit, 0);
        chk("R7 idle", seq_idle, 1);
        chk("R7 done", list_done, 1);
        chk("R7 ptr top", cmd_ptr, 0);
        tick(20);
        chk("R7 one store only", n_store - base, 1);
        sreset();

        // R8 restart mode: trigger after abort locks
        restart_mode = 1'b1;
        act(A_TSW); tick(30);
        act(A_ASW); tick(5);
        base = n_store;
        act(A_TSW); tick(30);
        chk("R8 trig_err", trig_err, 1);
        chk("R8 trig held", trig_bit, 1);
        chk("R8 no conversions", n_store - base, 0);
        act(A_RSW); tick(10);
        chk("R8 restart ignored", rstrt_bit, 0);
        chk("R12 trig_err sticky", trig_err, 1);
        sreset();
        chk("R8 soft reset clears", {trig_err, trig_bit}, 0);

        // R9 restart after abort, then trigger from top
        act(A_TSW); tick(30);
        act(A_ASW); tick(5);
        base = n_store;
        act(A_RSW); tick(20);
        chk("R9 no conversion", n_store - base, 0);
        chk("R9 rstrt cleared", rstrt_bit, 0);
        chk("R9 no error", rstrt_err, 0);
        act(A_TSW); tick(30);
        chk("R9 from top stores", n_store - base, 3);
        chk("R9 from top ptr", cmd_ptr, 3);
        chk("R9 no trig_err", trig_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule